// File: doc/BRIEF.md
# Register Scoreboard Issue Unit

This block sits between an instruction decoder and a group of functional units. Decoded instructions enter a small window that keeps them in age order. Each instruction names two source registers, one destination register and the class of unit it needs. Each cycle the block picks at most one instruction from the window and sends it to the units. It may pick an instruction only when that instruction conflicts with nothing still in flight and with nothing older still waiting in the window.

The scoreboard holds a reader count and a writer count for each architectural register, and a busy count for each unit class. There are two integer units, one floating-point unit and one load/store unit. Issuing an instruction raises its counts. The execution side reports each instruction when it retires, and those counts then fall. One input selects the issue mode. In strict program order, only the oldest waiting instruction may go. In out-of-order mode, a younger instruction that is free of every conflict may pass an older one that is stalled.

Top module: `sb_issue_unit`

## Requirements
- R1: An instruction is not issued while a pending writer (writer count non-zero) exists for either of its source registers.
- R2: An instruction is not issued while its destination register has a pending reader (reader count non-zero).
- R3: An instruction is not issued while its destination register has a pending writer.
- R4: The class codes are 0 for integer, 1 for floating point and 2 for load/store. At most 2 integer, 1 floating-point and 1 load/store instructions are in flight at once. An instruction whose class is at capacity waits, even when it has no register conflict.
- R5: With `ooo_mode` high, the oldest eligible window entry issues, even when older entries are stalled.
- R6: With `ooo_mode` low, only the oldest window entry may issue. When it is stalled, nothing issues.
- R7: An entry does not issue while any older entry still in the window writes one of its sources, reads its destination or writes its destination.
- R8: The window holds 4 entries in age order. `in_ready` is low exactly when all 4 are occupied. An `in_valid` pulse while `in_ready` is low adds nothing.
- R9: The 3-bit reader counts never pass 7. An instruction whose source reads would push a count beyond 7 waits. A source register named twice counts as two reads.
- R10: A retire lowers the reader counts of its sources, the writer count of its destination and the busy count of its class. An issue and a retire in the same cycle leave the net count.
- R11: Reset empties the window and clears every count. After reset, `iss_valid` is low and `in_ready` is high.
- R12: At most one instruction issues per cycle. The `iss_*` outputs show the chosen entry during the cycle, and that entry leaves the window at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ooo_mode | input | 1 | 1 = out-of-order issue, 0 = in-order issue |
| in_valid | input | 1 | Decoder offers an instruction |
| in_src0 | input | 3 | First source register |
| in_src1 | input | 3 | Second source register |
| in_dst | input | 3 | Destination register |
| in_cls | input | 2 | Unit class of the offered instruction |
| in_ready | output | 1 | Window has a free entry |
| iss_valid | output | 1 | An instruction issues this cycle |
| iss_src0 | output | 3 | First source of the issued instruction |
| iss_src1 | output | 3 | Second source of the issued instruction |
| iss_dst | output | 3 | Destination of the issued instruction |
| iss_cls | output | 2 | Class of the issued instruction |
| ret_valid | input | 1 | An in-flight instruction retires |
| ret_src0 | input | 3 | First source of the retiring instruction |
| ret_src1 | input | 3 | Second source of the retiring instruction |
| ret_dst | input | 3 | Destination of the retiring instruction |
| ret_cls | input | 2 | Class of the retiring instruction |

## Verification
The checks assume that a retire names an instruction that was issued earlier and has not yet retired. From that, no counter is ever decremented below zero. They also assume that class code 3 never appears on `in_cls` or `ret_cls`. The stimulus keeps to both: it retires only instructions it has already seen issue, copying their fields exactly, and it drives only the three legal class codes. Under those conditions the checks require that the hazard, capacity and saturation rules hold at every issue, and that counts stay within range.

// File: rtl/sb_pkg.sv
package sb_pkg;
  parameter int SB_NREG = 8;
  localparam int SB_REG_W = $clog2(SB_NREG);
  localparam int SB_NCLS = 3;

  typedef enum logic [1:0] {
    CLS_INT = 2'd0,
    CLS_FP  = 2'd1,
    CLS_LS  = 2'd2
  } fu_cls_e;

  typedef struct packed {
    logic [SB_REG_W-1:0] src0;
    logic [SB_REG_W-1:0] src1;
    logic [SB_REG_W-1:0] dst;
    fu_cls_e             cls;
  } sb_instr_t;
endpackage

// File: rtl/sb_window.sv
module sb_window
  import sb_pkg::*;
#(
  parameter int WIN = 4,
  localparam int IDX_W = $clog2(WIN),
  localparam int OCC_W = $clog2(WIN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enq,
  input  sb_instr_t        enq_ins,
  input  logic             deq,
  input  logic [IDX_W-1:0] deq_idx,
  output sb_instr_t        ent [WIN],
  output logic [OCC_W-1:0] occ,
  output logic             full
);

  sb_instr_t        ent_nxt [WIN];
  logic [OCC_W-1:0] occ_nxt;
  logic [OCC_W-1:0] occ_after;
  logic             upd_en;

  assign full   = (occ == OCC_W'(WIN));
  assign upd_en = enq | deq;

  // Close the gap left by the departing entry, then append at the tail.
  always_comb begin
    occ_after = occ - OCC_W'(deq);
    for (int i = 0; i < WIN; i++) begin
      if (deq && (IDX_W'(i) >= deq_idx)) begin
        ent_nxt[i] = ent[(i < WIN - 1) ? i + 1 : i];
      end else begin
        ent_nxt[i] = ent[i];
      end
    end
    if (enq) begin
      ent_nxt[IDX_W'(occ_after)] = enq_ins;
    end
    occ_nxt = occ_after + OCC_W'(enq);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ <= '0;
      for (int i = 0; i < WIN; i++) begin
        ent[i] <= '0;
      end
    end else if (upd_en) begin
      occ <= occ_nxt;
      for (int i = 0; i < WIN; i++) begin
        ent[i] <= ent_nxt[i];
      end
    end
  end

  p_full_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !deq) |=> (occ == $past(occ)));

  p_occ_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= OCC_W'(WIN));

  p_one_issue_r12: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ({1'b0, occ} + 1'b1 >= {1'b0, $past(occ)}));

endmodule

// File: rtl/sb_score.sv
module sb_score
  import sb_pkg::*;
#(
  parameter int CNT_W = 3,
  parameter int N_INT = 2,
  parameter int N_FP  = 1,
  parameter int N_LS  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             iss_en,
  input  sb_instr_t        iss_ins,
  input  logic             ret_en,
  input  sb_instr_t        ret_ins,
  output logic [CNT_W-1:0] rd_cnt [SB_NREG],
  output logic [CNT_W-1:0] wr_cnt [SB_NREG],
  output logic [CNT_W-1:0] busy   [SB_NCLS]
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] rd_nxt   [SB_NREG];
  logic [CNT_W-1:0] wr_nxt   [SB_NREG];
  logic [CNT_W-1:0] busy_nxt [SB_NCLS];
  logic             upd_en;

  assign upd_en = iss_en | ret_en;

  // Net update: increments from the issue, decrements from the retire.
  always_comb begin
    for (int r = 0; r < SB_NREG; r++) begin
      rd_nxt[r] = rd_cnt[r]
                + CNT_W'(iss_en && (iss_ins.src0 == SB_REG_W'(r)))
                + CNT_W'(iss_en && (iss_ins.src1 == SB_REG_W'(r)))
                - CNT_W'(ret_en && (ret_ins.src0 == SB_REG_W'(r)))
                - CNT_W'(ret_en && (ret_ins.src1 == SB_REG_W'(r)));
      wr_nxt[r] = wr_cnt[r]
                + CNT_W'(iss_en && (iss_ins.dst == SB_REG_W'(r)))
                - CNT_W'(ret_en && (ret_ins.dst == SB_REG_W'(r)));
    end
    for (int c = 0; c < SB_NCLS; c++) begin
      busy_nxt[c] = busy[c]
                  + CNT_W'(iss_en && (2'(iss_ins.cls) == 2'(c)))
                  - CNT_W'(ret_en && (2'(ret_ins.cls) == 2'(c)));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < SB_NREG; r++) begin
        rd_cnt[r] <= '0;
        wr_cnt[r] <= '0;
      end
      for (int c = 0; c < SB_NCLS; c++) begin
        busy[c] <= '0;
      end
    end else if (upd_en) begin
      for (int r = 0; r < SB_NREG; r++) begin
        rd_cnt[r] <= rd_nxt[r];
        wr_cnt[r] <= wr_nxt[r];
      end
      for (int c = 0; c < SB_NCLS; c++) begin
        busy[c] <= busy_nxt[c];
      end
    end
  end

  for (genvar r = 0; r < SB_NREG; r++) begin : g_reg_chk
    p_raw_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_en && ((iss_ins.src0 == SB_REG_W'(r)) || (iss_ins.src1 == SB_REG_W'(r))))
        |-> (wr_cnt[r] == '0));
    p_war_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_en && (iss_ins.dst == SB_REG_W'(r))) |-> (rd_cnt[r] == '0));
    p_waw_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_en && (iss_ins.dst == SB_REG_W'(r))) |-> (wr_cnt[r] == '0));
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_en && ((iss_ins.src0 == SB_REG_W'(r)) || (iss_ins.src1 == SB_REG_W'(r))))
        |-> (rd_cnt[r] != CNT_MAX));
    p_no_underflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_en && ((ret_ins.src0 == SB_REG_W'(r)) || (ret_ins.src1 == SB_REG_W'(r))))
        |-> (rd_cnt[r] != '0));
    p_wr_underflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_en && (ret_ins.dst == SB_REG_W'(r))) |-> (wr_cnt[r] != '0));
  end

  p_unit_int_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy[0] <= CNT_W'(N_INT));
  p_unit_fp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy[1] <= CNT_W'(N_FP));
  p_unit_ls_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy[2] <= CNT_W'(N_LS));

endmodule

// File: rtl/sb_pick.sv
module sb_pick
  import sb_pkg::*;
#(
  parameter int WIN   = 4,
  parameter int CNT_W = 3,
  parameter int N_INT = 2,
  parameter int N_FP  = 1,
  parameter int N_LS  = 1,
  localparam int IDX_W = $clog2(WIN),
  localparam int OCC_W = $clog2(WIN + 1)
) (
  input  sb_instr_t        ent    [WIN],
  input  logic [OCC_W-1:0] occ,
  input  logic [CNT_W-1:0] rd_cnt [SB_NREG],
  input  logic [CNT_W-1:0] wr_cnt [SB_NREG],
  input  logic [CNT_W-1:0] busy   [SB_NCLS],
  input  logic             ooo,
  output logic             grant_vld,
  output logic [IDX_W-1:0] grant_idx
);

  localparam logic [CNT_W:0] SAT_MAX = {1'b0, {CNT_W{1'b1}}};

  logic [WIN-1:0] elig;

  always_comb begin
    logic           blk_sb;
    logic           blk_win;
    logic           blk_unit;
    logic           blk_sat;
    logic [CNT_W:0] rd_sum;
    logic           twice;
    for (int i = 0; i < WIN; i++) begin
      // Hazards against in-flight instructions.
      blk_sb = (wr_cnt[ent[i].src0] != '0) || (wr_cnt[ent[i].src1] != '0)
            || (rd_cnt[ent[i].dst] != '0) || (wr_cnt[ent[i].dst] != '0);
      // Reader count headroom; a doubled source needs two steps.
      twice   = (ent[i].src0 == ent[i].src1);
      rd_sum  = {1'b0, rd_cnt[ent[i].src0]} + (twice ? (CNT_W+1)'(2) : (CNT_W+1)'(1));
      blk_sat = (rd_sum > SAT_MAX)
             || (!twice && (rd_cnt[ent[i].src1] == SAT_MAX[CNT_W-1:0]));
      // Unit capacity per class.
      case (ent[i].cls)
        CLS_INT: blk_unit = (busy[0] >= CNT_W'(N_INT));
        CLS_FP:  blk_unit = (busy[1] >= CNT_W'(N_FP));
        CLS_LS:  blk_unit = (busy[2] >= CNT_W'(N_LS));
        default: blk_unit = 1'b1;
      endcase
      // Hazards against older entries still waiting.
      blk_win = 1'b0;
      for (int j = 0; j < WIN; j++) begin
        if (j < i) begin
          blk_win = blk_win
                 || (ent[j].dst  == ent[i].src0) || (ent[j].dst  == ent[i].src1)
                 || (ent[j].src0 == ent[i].dst)  || (ent[j].src1 == ent[i].dst)
                 || (ent[j].dst  == ent[i].dst);
        end
      end
      elig[i] = (OCC_W'(i) < occ) && !blk_sb && !blk_sat && !blk_unit && !blk_win;
    end
  end

  // Oldest eligible entry wins; in-order mode looks at the head only.
  always_comb begin
    grant_vld = 1'b0;
    grant_idx = '0;
    if (ooo) begin
      for (int i = WIN - 1; i >= 0; i--) begin
        if (elig[i]) begin
          grant_vld = 1'b1;
          grant_idx = IDX_W'(i);
        end
      end
    end else begin
      grant_vld = elig[0];
    end
  end

endmodule

// File: rtl/sb_issue_unit.sv
module sb_issue_unit
  import sb_pkg::*;
#(
  parameter int WIN   = 4,
  parameter int CNT_W = 3,
  parameter int N_INT = 2,
  parameter int N_FP  = 1,
  parameter int N_LS  = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ooo_mode,
  input  logic                in_valid,
  input  logic [SB_REG_W-1:0] in_src0,
  input  logic [SB_REG_W-1:0] in_src1,
  input  logic [SB_REG_W-1:0] in_dst,
  input  logic [1:0]          in_cls,
  output logic                in_ready,
  output logic                iss_valid,
  output logic [SB_REG_W-1:0] iss_src0,
  output logic [SB_REG_W-1:0] iss_src1,
  output logic [SB_REG_W-1:0] iss_dst,
  output logic [1:0]          iss_cls,
  input  logic                ret_valid,
  input  logic [SB_REG_W-1:0] ret_src0,
  input  logic [SB_REG_W-1:0] ret_src1,
  input  logic [SB_REG_W-1:0] ret_dst,
  input  logic [1:0]          ret_cls
);

  localparam int IDX_W = $clog2(WIN);
  localparam int OCC_W = $clog2(WIN + 1);

  logic [1:0]       rst_pipe;
  logic             rst_i_n;
  sb_instr_t        ent [WIN];
  logic [OCC_W-1:0] occ;
  logic             full;
  logic             enq;
  logic             grant_vld;
  logic [IDX_W-1:0] grant_idx;
  sb_instr_t        new_ins;
  sb_instr_t        iss_ins;
  sb_instr_t        ret_ins;
  logic [CNT_W-1:0] rd_cnt [SB_NREG];
  logic [CNT_W-1:0] wr_cnt [SB_NREG];
  logic [CNT_W-1:0] busy   [SB_NCLS];

  // Reset: asserted at once, released on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_i_n = rst_pipe[1];

  assign new_ins  = '{src0: in_src0, src1: in_src1, dst: in_dst, cls: fu_cls_e'(in_cls)};
  assign ret_ins  = '{src0: ret_src0, src1: ret_src1, dst: ret_dst, cls: fu_cls_e'(ret_cls)};
  assign in_ready = ~full;
  assign enq      = in_valid & ~full;

  assign iss_ins   = ent[grant_idx];
  assign iss_valid = grant_vld;
  assign iss_src0  = iss_ins.src0;
  assign iss_src1  = iss_ins.src1;
  assign iss_dst   = iss_ins.dst;
  assign iss_cls   = 2'(iss_ins.cls);

  sb_window #(.WIN(WIN)) win_i (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .enq     (enq),
    .enq_ins (new_ins),
    .deq     (grant_vld),
    .deq_idx (grant_idx),
    .ent     (ent),
    .occ     (occ),
    .full    (full)
  );

  sb_score #(.CNT_W(CNT_W), .N_INT(N_INT), .N_FP(N_FP), .N_LS(N_LS)) score_i (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .iss_en  (grant_vld),
    .iss_ins (iss_ins),
    .ret_en  (ret_valid),
    .ret_ins (ret_ins),
    .rd_cnt  (rd_cnt),
    .wr_cnt  (wr_cnt),
    .busy    (busy)
  );

  sb_pick #(.WIN(WIN), .CNT_W(CNT_W), .N_INT(N_INT), .N_FP(N_FP), .N_LS(N_LS)) pick_i (
    .ent       (ent),
    .occ       (occ),
    .rd_cnt    (rd_cnt),
    .wr_cnt    (wr_cnt),
    .busy      (busy),
    .ooo       (ooo_mode),
    .grant_vld (grant_vld),
    .grant_idx (grant_idx)
  );

  p_inorder_r6: assert property (@(posedge clk) disable iff (!rst_i_n)
    (iss_valid && !ooo_mode) |-> (iss_ins == ent[0]));

  p_cls_legal_r4: assert property (@(posedge clk) disable iff (!rst_i_n)
    (in_valid |-> (in_cls != 2'd3)) and (ret_valid |-> (ret_cls != 2'd3)));

  p_no_empty_issue_r12: assert property (@(posedge clk) disable iff (!rst_i_n)
    iss_valid |-> (occ != '0));

endmodule

// File: tb/sb_issue_unit_tb_top.sv
module sb_issue_unit_tb_top;

  typedef struct packed {
    logic       ooo;
    logic       ev;
    logic [2:0] es0, es1, ed;
    logic [1:0] ec;
    logic       rv;
    logic [2:0] rs0, rs1, rdst;
    logic [1:0] rc;
    logic       xv;
    logic [2:0] xd;
    logic       xr;
  } vec_t;

  function automatic vec_t mk(int ooo, int ev, int es0, int es1, int ed, int ec,
                              int rv, int rs0, int rs1, int rd, int rc,
                              int xv, int xd, int xr);
    vec_t v;
    v.ooo = 1'(ooo); v.ev = 1'(ev);
    v.es0 = 3'(es0); v.es1 = 3'(es1); v.ed = 3'(ed); v.ec = 2'(ec);
    v.rv = 1'(rv); v.rs0 = 3'(rs0); v.rs1 = 3'(rs1); v.rdst = 3'(rd); v.rc = 2'(rc);
    v.xv = 1'(xv); v.xd = 3'(xd); v.xr = 1'(xr);
    return v;
  endfunction

  // Class codes: 0 integer, 1 floating point, 2 load/store.
  localparam int NVEC = 19;
  localparam vec_t TBL [NVEC] = '{
    mk(1,1,2,3,1,0, 0,0,0,0,0, 0,0,1), // A r1=r2+r3 int
    mk(1,1,1,5,4,0, 0,0,0,0,0, 1,1,1), // A issues; B r4=r1+r5 enters
    mk(1,1,2,7,6,1, 0,0,0,0,0, 0,0,1), // R1: B waits on r1
    mk(1,0,0,0,0,0, 0,0,0,0,0, 1,6,1), // R5: C passes B
    mk(1,1,0,0,2,2, 0,0,0,0,0, 0,0,1), // D r2=r0+r0 ls
    mk(1,0,0,0,0,0, 1,2,3,1,0, 0,0,1), // R2: D waits on readers of r2
    mk(1,0,0,0,0,0, 0,0,0,0,0, 1,4,1), // R10: retire of A frees B
    mk(1,0,0,0,0,0, 1,2,7,6,1, 0,0,1), // R2: C still reads r2
    mk(1,0,0,0,0,0, 0,0,0,0,0, 1,2,1), // D issues
    mk(0,1,4,0,7,0, 0,0,0,0,0, 0,0,1), // E r7=r4+r0
    mk(0,1,0,6,3,1, 0,0,0,0,0, 0,0,1), // F r3=r0+r6
    mk(0,0,0,0,0,0, 0,0,0,0,0, 0,0,1), // R6: head E stalls, F held
    mk(1,0,0,0,0,0, 0,0,0,0,0, 1,3,1), // R5: out-of-order lets F go
    mk(1,0,0,0,0,0, 1,1,5,4,0, 0,0,1), // retire B
    mk(1,0,0,0,0,0, 0,0,0,0,0, 1,7,1), // E issues
    mk(1,1,0,0,7,0, 0,0,0,0,0, 0,0,1), // G r7=r0+r0
    mk(1,0,0,0,0,0, 0,0,0,0,0, 0,0,1), // R3: G waits on writer of r7
    mk(1,0,0,0,0,0, 1,4,0,7,0, 0,0,1), // retire E
    mk(1,0,0,0,0,0, 0,0,0,0,0, 1,7,1)  // R3: G issues
  };

  logic       clk;
  logic       rst_n;
  logic       ooo_mode;
  logic       in_valid;
  logic [2:0] in_src0, in_src1, in_dst;
  logic [1:0] in_cls;
  logic       in_ready;
  logic       iss_valid;
  logic [2:0] iss_src0, iss_src1, iss_dst;
  logic [1:0] iss_cls;
  logic       ret_valid;
  logic [2:0] ret_src0, ret_src1, ret_dst;
  logic [1:0] ret_cls;

  int checks;
  int errors;
  bit done;

  sb_issue_unit dut_i (
    .clk(clk), .rst_n(rst_n), .ooo_mode(ooo_mode),
    .in_valid(in_valid), .in_src0(in_src0), .in_src1(in_src1), .in_dst(in_dst),
    .in_cls(in_cls), .in_ready(in_ready),
    .iss_valid(iss_valid), .iss_src0(iss_src0), .iss_src1(iss_src1),
    .iss_dst(iss_dst), .iss_cls(iss_cls),
    .ret_valid(ret_valid), .ret_src0(ret_src0), .ret_src1(ret_src1),
    .ret_dst(ret_dst), .ret_cls(ret_cls)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic stp(string tag, vec_t v);
    @(negedge clk);
    ooo_mode = v.ooo;
    in_valid = v.ev; in_src0 = v.es0; in_src1 = v.es1; in_dst = v.ed; in_cls = v.ec;
    ret_valid = v.rv; ret_src0 = v.rs0; ret_src1 = v.rs1; ret_dst = v.rdst; ret_cls = v.rc;
    #1;
    chk({tag, " iss_valid"}, int'(iss_valid), int'(v.xv));
    if (v.xv) chk({tag, " iss_dst"}, int'(iss_dst), int'(v.xd));
    chk({tag, " in_ready"}, int'(in_ready), int'(v.xr));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    ooo_mode = 1'b1; in_valid = 1'b0; ret_valid = 1'b0;
    in_src0 = '0; in_src1 = '0; in_dst = '0; in_cls = '0;
    ret_src0 = '0; ret_src1 = '0; ret_dst = '0; ret_cls = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    do_reset();

    // R11: state straight after reset
    stp("R11 reset", mk(1,0,0,0,0,0, 0,0,0,0,0, 0,0,1));

    for (int k = 0; k < NVEC; k++) begin
      stp($sformatf("R1..R6 table row %0d", k), TBL[k]);
    end

    // R8: fill the window, refuse a fifth entry, drain oldest first (R5, R12)
    do_reset();
    stp("R8 fill0",      mk(1,1,0,0,1,0, 0,0,0,0,0, 0,0,1)); // X r1=r0+r0 int
    stp("R12 X issues",  mk(1,1,1,0,2,0, 0,0,0,0,0, 1,1,1)); // W0 r2
    stp("R1 W0 waits",   mk(1,1,1,0,3,1, 0,0,0,0,0, 0,0,1)); // W1 r3 fp
    stp("R8 fill2",      mk(1,1,1,0,4,2, 0,0,0,0,0, 0,0,1)); // W2 r4 ls
    stp("R8 fill3",      mk(1,1,1,0,5,0, 0,0,0,0,0, 0,0,1)); // W3 r5 int
    stp("R8 full",       mk(1,1,0,0,6,1, 0,0,0,0,0, 0,0,0)); // refused
    stp("R8 still full", mk(1,0,0,0,0,0, 1,0,0,1,0, 0,0,0)); // retire X
    stp("R5 oldest W0",  mk(1,0,0,0,0,0, 0,0,0,0,0, 1,2,0));
    stp("R5 next W1",    mk(1,0,0,0,0,0, 0,0,0,0,0, 1,3,1));
    stp("R5 next W2",    mk(1,0,0,0,0,0, 0,0,0,0,0, 1,4,1));
    stp("R4 second int", mk(1,0,0,0,0,0, 0,0,0,0,0, 1,5,1));
    stp("R8 refused gone", mk(1,0,0,0,0,0, 0,0,0,0,0, 0,0,1));

    // R4 unit capacity, R10 net count on same-cycle issue and retire
    stp("R4 enq U",      mk(1,1,0,0,6,0, 0,0,0,0,0, 0,0,1));
    stp("R4 int full",   mk(1,0,0,0,0,0, 1,1,0,2,0, 0,0,1)); // retire W0
    stp("R10 U issues",  mk(1,1,0,0,7,0, 1,1,0,5,0, 1,6,1)); // retire W3, enq V
    stp("R10 net busy",  mk(1,0,0,0,0,0, 0,0,0,0,0, 1,7,1));

    // R9 reader count saturation with doubled sources
    do_reset();
    stp("R9 enq S0",     mk(1,1,3,3,1,0, 0,0,0,0,0, 0,0,1));
    stp("R9 S0",         mk(1,1,3,3,2,0, 0,0,0,0,0, 1,1,1));
    stp("R9 S1",         mk(1,1,3,3,4,1, 0,0,0,0,0, 1,2,1));
    stp("R9 S2",         mk(1,1,3,3,5,2, 0,0,0,0,0, 1,4,1));
    stp("R9 S3 held",    mk(1,0,0,0,0,0, 0,0,0,0,0, 0,0,1));
    stp("R9 S3 held2",   mk(1,0,0,0,0,0, 1,3,3,1,0, 0,0,1)); // retire S0
    stp("R9 S3 issues",  mk(1,0,0,0,0,0, 0,0,0,0,0, 1,5,1));

    // R7 hazard against an older waiting entry
    do_reset();
    stp("R7 enq X",      mk(1,1,0,0,1,0, 0,0,0,0,0, 0,0,1));
    stp("R7 X",          mk(1,1,1,0,2,0, 0,0,0,0,0, 1,1,1)); // Y r2=r1+r0
    stp("R7 Y waits",    mk(1,1,2,0,3,1, 0,0,0,0,0, 0,0,1)); // Z r3=r2+r0
    stp("R7 Z blocked",  mk(1,0,0,0,0,0, 0,0,0,0,0, 0,0,1));
    stp("R7 retire X",   mk(1,0,0,0,0,0, 1,0,0,1,0, 0,0,1));
    stp("R7 Y issues",   mk(1,0,0,0,0,0, 0,0,0,0,0, 1,2,1));
    stp("R1 Z waits",    mk(1,0,0,0,0,0, 0,0,0,0,0, 0,0,1));

    // R11: reset with work pending clears window and counts
    do_reset();
    stp("R11 empty",     mk(1,0,0,0,0,0, 0,0,0,0,0, 0,0,1));
    stp("R11 enq K",     mk(1,1,2,2,3,0, 0,0,0,0,0, 0,0,1));
    stp("R11 cleared",   mk(1,0,0,0,0,0, 0,0,0,0,0, 1,3,1));

    done = 1'b1;
    finish_run();
  end

endmodule